// File: doc/BRIEF.md
# Configurable Asynchronous Frame Serializer

This block turns one character at a time into an asynchronous serial frame on a single output line. The line format comes from a set of static control inputs. They choose five to eight data bits, an optional parity bit (even, odd, or forced to a fixed level), one or two stop bits, and a break command that pulls the line low. A byte is handed over through a valid/ready handshake. The frame then advances one bit for each pulse of an external bit-rate strobe supplied by a baud generator.

While a character is in flight the block raises a busy flag. When the last stop bit has finished, it drops busy and gives a one-cycle end-of-transmission pulse. Everything except the break input is captured when the byte is accepted, so a host may change the format for the next character while the current one is still going out. Break is sampled live. When break is raised, the character in progress completes, and the line is then held low for as long as break stays set.

Top module: `uart_frame_tx`

## Requirements
- R1: The 2-bit word-length input selects the data bit count: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits follow a start bit at level 0 and are sent least significant bit first. Input bits above the selected length are not sent.
- R2: With parity disabled, the first stop bit directly follows the last data bit.
- R3: With parity enabled and stick parity off, the parity bit follows the data. Even select set makes the count of ones over data and parity even; even select clear makes it odd.
- R4: With stick parity and parity enabled, the parity bit is 0 when even select is set and 1 when it is clear, whatever the data.
- R5: The stop-bit select sends one stop bit (when 0) or two stop bits (when 1), all at level 1. The idle line is at level 1.
- R6: Each frame bit lasts exactly one strobe period. The start bit begins at the first strobe edge after acceptance, and the line changes only at strobe edges while a frame is in flight.
- R7: busy is 1 from the cycle after acceptance until the strobe edge that ends the final stop bit. At that edge busy falls and eot is 1 for exactly one cycle.
- R8: in_ready is 1 only when the block is not busy and break is 0. A byte is accepted on a clock edge where in_valid and in_ready are both 1. While break is set, in_valid starts no frame.
- R9: With break set, the character in progress completes unchanged. The line then goes to 0 at the edge that ends the final stop bit (or on the next clock edge if the block is idle), stays 0 while break is held, and returns to 1 on the clock edge after break clears.
- R10: After a synchronous active-low reset, txd is 1, busy and eot are 0, and in_ready is 1 when break is 0. A reset during a frame abandons it.
- R11: Word length, parity enable, even select, stick parity and stop-bit select are captured at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-rate strobe from the baud generator |
| cfg_wlen | input | 2 | Word length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_even | input | 1 | Even parity select (stick parity: level select, 1 gives 0) |
| cfg_stick | input | 1 | Stick parity enable |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_brk | input | 1 | Break command, holds the line low after the current character |
| in_data | input | MAX_BITS | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Character in flight |
| eot | output | 1 | One-cycle pulse when the final stop bit has left |

## Verification
Acceptance takes effect at the accepting edge, so busy is checked at the falling clock edge right after it, while the line is still high. Each frame bit is registered at a strobe edge and is sampled at the falling edge that follows that strobe edge. One extra strobe edge after the last stop bit makes busy fall, makes eot show, and makes the line take its break or idle level. The bench checks these at that falling edge, and checks one cycle later that eot has gone.

Break entered while idle, and break release, each take one clock edge and are checked one falling edge later. The strobe is driven only on falling edges, so the value the design sees at each rising edge is unambiguous.

// File: rtl/uart_frame_pkg.sv
// Package: shared phase encoding and word-length decode for the frame
// serializer. Assumes the word-length code is two bits wide.
package uart_frame_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_phase_t;

    // Number of data bits selected by a word-length code (5..8).
    function automatic logic [3:0] bits_for(input logic [1:0] wl);
        return 4'd5 + {2'b00, wl};
    endfunction

endpackage

// File: rtl/uart_tx_parity.sv
// Module: computes the parity bit for one character from the live inputs,
// masking data bits above the selected word length. The stick mode forces
// the level. Assumes MAX_BITS is at most 8 (word length codes reach 8 bits).
module uart_tx_parity #(
    parameter int MAX_BITS = 8
) (
    input  logic [MAX_BITS-1:0] data,
    input  logic [1:0]          wlen,
    input  logic                even_sel,
    input  logic                stick,
    output logic                par_bit
);
    import uart_frame_pkg::*;

    logic [3:0]          nbits;
    logic [MAX_BITS-1:0] masked;
    logic                ones_odd;

    assign nbits = bits_for(wlen);

    // Keep only the bits that will actually be sent.
    for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
        assign masked[i] = data[i] & (4'(i) < nbits);
    end

    assign ones_odd = ^masked;

    // Pick the parity level: forced in stick mode, else balance the ones.
    always_comb begin
        if (stick)         par_bit = ~even_sel;
        else if (even_sel) par_bit = ones_odd;
        else               par_bit = ~ones_odd;
    end

endmodule

// File: rtl/uart_tx_shifter.sv
// Module: frame sequencer and shifter. Captures one character and its
// format on load, waits for the next strobe, then emits start, data (LSB
// first), optional parity and stop bits, one per strobe. txd is registered.
// Assumes load is only raised while idle and break is low.
module uart_tx_shifter #(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                load,
    input  logic [MAX_BITS-1:0] data,
    input  logic [1:0]          wlen,
    input  logic                par_en,
    input  logic                par_in,
    input  logic                two_stop,
    input  logic                brk,
    output logic                txd,
    output logic                idle,
    output logic                done
);
    import uart_frame_pkg::*;

    localparam int CNT_W = $clog2(MAX_BITS);

    tx_phase_t           phase;
    logic [MAX_BITS-1:0] shreg;
    logic [CNT_W-1:0]    left;
    logic                par_q;
    logic                pen_q;
    logic                two_q;
    logic                stop_more;
    logic                txd_q;
    logic                done_q;

    // Advance the frame one bit per strobe and register the line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= S_IDLE;
            shreg     <= '0;
            left      <= '0;
            par_q     <= 1'b0;
            pen_q     <= 1'b0;
            two_q     <= 1'b0;
            stop_more <= 1'b0;
            txd_q     <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                S_IDLE: begin
                    txd_q <= ~brk;
                    if (load) begin
                        phase <= S_WAIT;
                        shreg <= data;
                        left  <= CNT_W'(bits_for(wlen) - 4'd1);
                        par_q <= par_in;
                        pen_q <= par_en;
                        two_q <= two_stop;
                    end
                end
                S_WAIT: begin
                    if (bit_tick) begin
                        phase <= S_START;
                        txd_q <= 1'b0;
                    end
                end
                S_START: begin
                    if (bit_tick) begin
                        phase <= S_DATA;
                        txd_q <= shreg[0];
                    end
                end
                S_DATA: begin
                    if (bit_tick) begin
                        if (left != '0) begin
                            shreg <= shreg >> 1;
                            left  <= left - 1'b1;
                            txd_q <= shreg[1];
                        end else if (pen_q) begin
                            phase <= S_PAR;
                            txd_q <= par_q;
                        end else begin
                            phase     <= S_STOP;
                            txd_q     <= 1'b1;
                            stop_more <= two_q;
                        end
                    end
                end
                S_PAR: begin
                    if (bit_tick) begin
                        phase     <= S_STOP;
                        txd_q     <= 1'b1;
                        stop_more <= two_q;
                    end
                end
                S_STOP: begin
                    if (bit_tick) begin
                        if (stop_more) begin
                            stop_more <= 1'b0;
                        end else begin
                            phase  <= S_IDLE;
                            txd_q  <= ~brk;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: phase <= S_IDLE;
            endcase
        end
    end

    assign txd  = txd_q;
    assign idle = (phase == S_IDLE);
    assign done = done_q;

    // R5
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_STOP) |-> txd_q);

    // R6
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != S_IDLE && $past(phase) != S_IDLE && !$past(bit_tick))
            |-> $stable(txd_q));

    // R9
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == S_IDLE && $past(phase) == S_IDLE && $past(brk)) |-> !txd_q);

    // R7
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (phase == S_IDLE && $past(phase) == S_STOP));

endmodule

// File: rtl/uart_frame_tx.sv
// Module: top of the frame serializer. Qualifies the handshake, computes
// the parity bit from the offered character and hands both to the
// sequencer. Assumes bit_tick is a one-cycle pulse per bit period.
module uart_frame_tx #(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_par_en,
    input  logic                cfg_even,
    input  logic                cfg_stick,
    input  logic                cfg_two_stop,
    input  logic                cfg_brk,
    input  logic [MAX_BITS-1:0] in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                txd,
    output logic                busy,
    output logic                eot
);
    logic par_bit;
    logic idle;
    logic load;

    assign in_ready = idle & ~cfg_brk;
    assign load     = in_valid & in_ready;
    assign busy     = ~idle;

    uart_tx_parity #(.MAX_BITS(MAX_BITS)) u_parity (
        .data     (in_data),
        .wlen     (cfg_wlen),
        .even_sel (cfg_even),
        .stick    (cfg_stick),
        .par_bit  (par_bit)
    );

    uart_tx_shifter #(.MAX_BITS(MAX_BITS)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .load     (load),
        .data     (in_data),
        .wlen     (cfg_wlen),
        .par_en   (cfg_par_en),
        .par_in   (par_bit),
        .two_stop (cfg_two_stop),
        .brk      (cfg_brk),
        .txd      (txd),
        .idle     (idle),
        .done     (eot)
    );

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R7
    eot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot);

    // R7
    eot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> (!busy && $past(busy)));

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] wl;
        logic       pe;
        logic       ev;
        logic       st;
        logic       two;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h1F, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'h2C, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{8'h7F, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
        '{8'hC3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0},
        '{8'h00, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0},
        '{8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8'h5A, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_brk = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       txd;
    logic       busy;
    logic       eot;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int tcnt = 0;

    logic  exp_bits [12];
    string exp_tag  [12];
    int    exp_n;

    uart_frame_tx u_uart_frame_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_even     (cfg_even),
        .cfg_stick    (cfg_stick),
        .cfg_two_stop (cfg_two_stop),
        .cfg_brk      (cfg_brk),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .txd          (txd),
        .busy         (busy),
        .eot          (eot)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected=<100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Bit strobe: one cycle in four, changed on falling edges only.
    initial begin
        forever begin
            @(negedge clk);
            bit_tick = (tcnt == 3);
            tcnt = (tcnt == 3) ? 0 : tcnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Return at the falling edge after the next rising edge that saw a strobe.
    task automatic wait_tick();
        do @(posedge clk); while (bit_tick !== 1'b1);
        @(negedge clk);
    endtask

    // Expected frame from the requirements.
    task automatic build(input vec_t v);
        int  n;
        int  idx;
        logic ones;
        logic par;
        n = 5 + int'(v.wl);
        ones = 1'b0;
        exp_bits[0] = 1'b0;
        exp_tag[0]  = "R6 start";
        for (int i = 0; i < n; i++) begin
            exp_bits[1+i] = v.d[i];
            exp_tag[1+i]  = "R1 data";
            ones = ones ^ v.d[i];
        end
        idx = 1 + n;
        if (v.pe) begin
            if (v.st)      par = ~v.ev;
            else if (v.ev) par = ones;
            else           par = ~ones;
            exp_bits[idx] = par;
            exp_tag[idx]  = v.st ? "R4 parity" : "R3 parity";
            idx++;
        end
        exp_bits[idx] = 1'b1;
        exp_tag[idx]  = v.pe ? "R5 stop" : "R2 stop";
        idx++;
        if (v.two) begin
            exp_bits[idx] = 1'b1;
            exp_tag[idx]  = "R5 stop2";
            idx++;
        end
        exp_n = idx;
    endtask

    task automatic apply_cfg(input vec_t v);
        cfg_wlen     = v.wl;
        cfg_par_en   = v.pe;
        cfg_even     = v.ev;
        cfg_stick    = v.st;
        cfg_two_stop = v.two;
    endtask

    // Send one character and check every bit, busy, ready and eot.
    task automatic run_frame(input vec_t v, input logic chg_cfg, input logic brk_mid);
        build(v);
        @(negedge clk);
        apply_cfg(v);
        in_data = v.d;
        check("R8 ready idle", 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~v.d;
        if (chg_cfg) begin
            cfg_wlen     = ~v.wl;
            cfg_par_en   = ~v.pe;
            cfg_even     = ~v.ev;
            cfg_stick    = ~v.st;
            cfg_two_stop = ~v.two;
        end
        if (brk_mid) cfg_brk = 1'b1;
        check("R7 busy after accept", 32'(busy), 32'd1);
        check("R6 line high before start", 32'(txd), 32'd1);
        for (int k = 0; k < exp_n; k++) begin
            wait_tick();
            check(chg_cfg ? "R11 frame bit" : exp_tag[k], 32'(txd), 32'(exp_bits[k]));
            check("R7 busy in frame", 32'(busy), 32'd1);
            check("R8 not ready in frame", 32'(in_ready), 32'd0);
        end
        wait_tick();
        check("R7 busy falls", 32'(busy), 32'd0);
        check("R7 eot pulse", 32'(eot), 32'd1);
        check(brk_mid ? "R9 break after frame" : "R5 idle high", 32'(txd), brk_mid ? 32'd0 : 32'd1);
        @(negedge clk);
        check("R7 eot one cycle", 32'(eot), 32'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 txd", 32'(txd), 32'd1);
        check("R10 busy", 32'(busy), 32'd0);
        check("R10 eot", 32'(eot), 32'd0);
        check("R10 in_ready", 32'(in_ready), 32'd1);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i], 1'b0, 1'b0);
        end

        // R11: format changes during a frame are ignored
        run_frame(VECS[4], 1'b1, 1'b0);
        run_frame(VECS[1], 1'b1, 1'b0);
        @(negedge clk);
        apply_cfg(VECS[0]);

        // R9: break during a frame
        run_frame(VECS[7], 1'b0, 1'b1);
        check("R8 no ready in break", 32'(in_ready), 32'd0);
        in_data  = 8'h3C;
        in_valid = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 break blocks accept", 32'(busy), 32'd0);
        check("R9 held low", 32'(txd), 32'd0);
        in_valid = 1'b0;
        cfg_brk  = 1'b0;
        @(negedge clk);
        check("R9 release high", 32'(txd), 32'd1);
        check("R8 ready after break", 32'(in_ready), 32'd1);

        // R9: break while idle
        cfg_brk = 1'b1;
        @(negedge clk);
        check("R9 idle break low", 32'(txd), 32'd0);
        repeat (3) @(negedge clk);
        check("R9 idle break holds", 32'(txd), 32'd0);
        cfg_brk = 1'b0;
        @(negedge clk);
        check("R9 idle release", 32'(txd), 32'd1);

        // R10: reset mid-frame abandons it
        @(negedge clk);
        in_data  = 8'h00;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        wait_tick();
        wait_tick();
        check("R10 frame running", 32'(busy), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset txd", 32'(txd), 32'd1);
        check("R10 reset busy", 32'(busy), 32'd0);
        @(negedge clk);

        // Frame right after reset still correct
        run_frame(VECS[2], 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule